// File: doc/BRIEF.md
# Scatter-Gather Request Packetizer

This block sits between a processing element and a memory fabric. It takes single memory requests (stores carrying an address, a data word and per-byte valid bits, and loads carrying only an address) and packs them into fixed 64-byte bursts. Each burst carries several independent address tuples instead of one contiguous line, so only useful bytes cross the link.

Every request names a destination, and each destination has its own packing buffer, so requests from one source are split into separate per-destination bursts. Loads and stores never share a burst. A burst leaves when its slots are full, when the other request type arrives for that destination, or when the destination has had no new request for a programmable number of cycles. One output port with a valid/ready handshake carries the burst, its destination, a type bit, the slot count and the per-byte valid bits.

Top module: `sg_packer`

## Requirements
- R1: A store burst has out_kind = 1. Store slot i places its address at out_payload[128i+63:128i] and its data at out_payload[128i+127:128i+64], and its byte-valid bits at out_byte_en[8i+7:8i].
- R2: A load burst has out_kind = 0 and out_byte_en all zero. Load slot i places its address at out_payload[64i+63:64i].
- R3: A buffer is flushed in the cycle its 4th store or 8th load is accepted. From then until its burst is taken at the output, the ready of any input aimed at that destination is low.
- R4: A partly filled buffer presents its burst on out_valid after exactly idle_limit clock edges with no accepted request for it (a limit of 0 acts as 1).
- R5: out_count equals the number of filled slots; unused payload slots and their byte-valid bits are zero.
- R6: Slots appear in the order in which their requests were accepted.
- R7: A request of the other type for a non-empty buffer is held off (ready low) and causes the held burst to flush; the request is accepted once that burst has left.
- R8: Requests to different destinations never share a burst; out_dest names the destination of the presented burst.
- R9: When both inputs target the same destination in one cycle, the store is taken and ld_ready is low; for different destinations both may be taken in the same cycle.
- R10: While out_valid is high and out_ready low, the presented burst, its header and out_dest stay unchanged, even if a lower-index destination becomes ready to send.
- R11: Reset (rst_n low at a clock edge) empties every buffer and discards partly filled bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_limit | input | 8 | Idle cycles before a partial burst is flushed |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store request accepted this cycle |
| st_dest | input | 1 | Store destination index |
| st_addr | input | 64 | Store address |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte-valid bits |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Load request accepted this cycle |
| ld_dest | input | 1 | Load destination index |
| ld_addr | input | 64 | Load address |
| out_valid | output | 1 | Burst present |
| out_ready | input | 1 | Fabric takes the burst |
| out_dest | output | 1 | Destination of the burst |
| out_kind | output | 1 | 1 = store burst, 0 = load burst |
| out_count | output | 4 | Number of filled slots (1 to 8) |
| out_byte_en | output | 32 | Byte-valid bits, 8 per store slot |
| out_payload | output | 512 | Burst body |

## Verification
Full store and full load sequences with distinct per-slot values show slot placement, ordering and the full-flush blocking of ready. A single lone load with a short idle limit separates the timeout flush from the full flush and measures its exact cycle, while a load arriving behind two stores distinguishes the type-conflict flush from both. Simultaneous requests to one and to two destinations tell the priority rule apart from independent per-destination acceptance, and a burst left waiting while another destination fills shows that the output holds its choice.

// File: rtl/sg_pkg.sv
// Shared type for the scatter-gather packetizer: the burst type code.
package sg_pkg;
    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } sg_kind_e;
endpackage

// File: rtl/sg_idle_timer.sv
// Idle timer for one packing buffer.
// Counts clock edges with no accepted request while the buffer is
// active; expire is high in the cycle whose edge reaches the limit.
// Assumes limit is held stable while a buffer is partly filled.
module sg_idle_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] limit,
    input  logic             active,
    input  logic             kick,
    output logic             expire
);
    logic [TMO_W-1:0] idle_q;
    logic [TMO_W:0]   next_idle;

    // Next idle count and expiry test (a limit of zero acts as one).
    always_comb begin
        next_idle = {1'b0, idle_q} + (TMO_W+1)'(1);
        expire    = active && !kick && (next_idle >= {1'b0, limit});
    end

    // Idle counter: cleared by an accept or while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || kick || expire) idle_q <= '0;
        else                                     idle_q <= next_idle[TMO_W-1:0];
    end
endmodule

// File: rtl/sg_dest_buffer.sv
// Packing buffer for one destination.
// Appends accepted stores (address+data, 128-bit slots) or loads
// (address, 64-bit slots) in arrival order and raises pending when the
// burst must leave: full, type conflict or idle timeout. While pending
// it accepts nothing; send empties it. Assumes the caller only asserts
// st_acc/ld_acc when the matching can_* output is high.
module sg_dest_buffer
    import sg_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 64,
    parameter int BURST_W = 512,
    parameter int TMO_W   = 8,
    localparam int BE_W     = DATA_W / 8,
    localparam int ST_SLOTW = ADDR_W + DATA_W,
    localparam int ST_SLOTS = BURST_W / ST_SLOTW,
    localparam int LD_SLOTS = BURST_W / ADDR_W,
    localparam int CNT_W    = $clog2(LD_SLOTS + 1),
    localparam int BEN_W    = ST_SLOTS * BE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TMO_W-1:0]   idle_limit,
    input  logic               st_req,
    input  logic               ld_req,
    input  logic               st_acc,
    input  logic               ld_acc,
    input  logic [ADDR_W-1:0]  st_addr,
    input  logic [DATA_W-1:0]  st_data,
    input  logic [BE_W-1:0]    st_be,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic               send,
    output logic               st_can,
    output logic               ld_can,
    output logic               pending,
    output sg_kind_e           kind,
    output logic [CNT_W-1:0]   count,
    output logic [BURST_W-1:0] payload,
    output logic [BEN_W-1:0]   byte_en
);
    logic               pending_q;
    sg_kind_e           kind_q;
    logic [CNT_W-1:0]   count_q;
    logic [BURST_W-1:0] pay_q;
    logic [BEN_W-1:0]   be_q;
    logic               conflict, st_full, ld_full, expire, active;

    // Acceptance rules and flush causes.
    always_comb begin
        st_can   = !pending_q && (count_q == '0 || kind_q == KIND_STORE);
        ld_can   = !pending_q && (count_q == '0 || kind_q == KIND_LOAD);
        conflict = !pending_q && count_q != '0 &&
                   ((st_req && kind_q == KIND_LOAD) || (ld_req && kind_q == KIND_STORE));
        st_full  = st_acc && count_q == CNT_W'(ST_SLOTS - 1);
        ld_full  = ld_acc && count_q == CNT_W'(LD_SLOTS - 1);
        active   = !pending_q && count_q != '0;
    end

    sg_idle_timer #(.TMO_W(TMO_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .limit  (idle_limit),
        .active (active),
        .kick   (st_acc || ld_acc),
        .expire (expire)
    );

    // Slot storage, fill count, type and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n || send) begin
            pending_q <= 1'b0;
            kind_q    <= KIND_LOAD;
            count_q   <= '0;
            pay_q     <= '0;
            be_q      <= '0;
        end else begin
            if (st_acc) begin
                pay_q[int'(count_q)*ST_SLOTW +: ST_SLOTW] <= {st_data, st_addr};
                be_q[int'(count_q)*BE_W +: BE_W]          <= st_be;
                kind_q  <= KIND_STORE;
                count_q <= count_q + CNT_W'(1);
            end else if (ld_acc) begin
                pay_q[int'(count_q)*ADDR_W +: ADDR_W] <= ld_addr;
                kind_q  <= KIND_LOAD;
                count_q <= count_q + CNT_W'(1);
            end
            if (st_full || ld_full || conflict || expire) pending_q <= 1'b1;
        end
    end

    assign pending = pending_q;
    assign kind    = kind_q;
    assign count   = count_q;
    assign payload = pay_q;
    assign byte_en = be_q;

    // R3: a pending buffer takes no request until its burst is sent.
    a_r3_no_accept_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !(st_acc || ld_acc));
    // R7: a store is only appended to an empty or store-holding buffer.
    a_r7_no_mixed_store: assert property (@(posedge clk) disable iff (!rst_n)
        (st_acc && count_q != '0) |-> kind_q == KIND_STORE);
    // R7: a load is only appended to an empty or load-holding buffer.
    a_r7_no_mixed_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_acc && count_q != '0) |-> kind_q == KIND_LOAD);
    // R3: the slot count never passes the capacity of its type.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'((kind_q == KIND_STORE) ? ST_SLOTS : LD_SLOTS));
endmodule

// File: rtl/sg_out_arb.sv
// Output selector: presents the lowest-index pending destination and
// keeps that choice while the fabric stalls. grant marks the buffer
// whose burst is taken in this cycle.
module sg_out_arb #(
    parameter int NUM_DEST = 2,
    localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DEST-1:0] pending,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [DEST_W-1:0]   sel,
    output logic [NUM_DEST-1:0] grant
);
    logic              hold_q;
    logic [DEST_W-1:0] hold_idx_q;
    logic [DEST_W-1:0] pick;

    // Fixed priority pick, overridden by a held choice.
    always_comb begin
        pick = '0;
        for (int i = NUM_DEST - 1; i >= 0; i--)
            if (pending[i]) pick = DEST_W'(i);
        out_valid = |pending;
        sel       = hold_q ? hold_idx_q : pick;
        for (int i = 0; i < NUM_DEST; i++)
            grant[i] = out_valid && out_ready && (sel == DEST_W'(i));
    end

    // Remember the presented destination across a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else begin
            hold_q     <= out_valid && !out_ready;
            hold_idx_q <= sel;
        end
    end

    // R10: a stalled choice is kept on the next cycle.
    a_r10_hold_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && sel == $past(sel)));
    // R8: at most one buffer is granted per cycle.
    a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/sg_packer.sv
// Scatter-gather request packetizer (top).
// Routes each store or load request to the packing buffer of its
// destination, applies store-over-load priority for a shared
// destination, and muxes the selected burst onto one output port.
// Assumes destination indices below NUM_DEST; others are never ready.
module sg_packer
    import sg_pkg::*;
#(
    parameter int NUM_DEST = 2,
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 64,
    parameter int BURST_W  = 512,
    parameter int TMO_W    = 8,
    localparam int DEST_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    localparam int BE_W     = DATA_W / 8,
    localparam int ST_SLOTS = BURST_W / (ADDR_W + DATA_W),
    localparam int LD_SLOTS = BURST_W / ADDR_W,
    localparam int CNT_W    = $clog2(LD_SLOTS + 1),
    localparam int BEN_W    = ST_SLOTS * BE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TMO_W-1:0]   idle_limit,
    input  logic               st_valid,
    output logic               st_ready,
    input  logic [DEST_W-1:0]  st_dest,
    input  logic [ADDR_W-1:0]  st_addr,
    input  logic [DATA_W-1:0]  st_data,
    input  logic [BE_W-1:0]    st_be,
    input  logic               ld_valid,
    output logic               ld_ready,
    input  logic [DEST_W-1:0]  ld_dest,
    input  logic [ADDR_W-1:0]  ld_addr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DEST_W-1:0]  out_dest,
    output logic               out_kind,
    output logic [CNT_W-1:0]   out_count,
    output logic [BEN_W-1:0]   out_byte_en,
    output logic [BURST_W-1:0] out_payload
);
    logic [NUM_DEST-1:0] st_can, ld_can, pend, grant;
    logic [NUM_DEST-1:0] st_req, ld_req, st_acc, ld_acc;
    sg_kind_e            kind_a [NUM_DEST];
    logic [CNT_W-1:0]    cnt_a  [NUM_DEST];
    logic [BURST_W-1:0]  pay_a  [NUM_DEST];
    logic [BEN_W-1:0]    be_a   [NUM_DEST];
    logic [DEST_W-1:0]   sel;
    logic                same_dest;

    // Input routing, readiness and store-first priority.
    always_comb begin
        same_dest = st_valid && ld_valid && (st_dest == ld_dest);
        st_ready  = 1'b0;
        ld_ready  = 1'b0;
        for (int d = 0; d < NUM_DEST; d++) begin
            st_req[d] = st_valid && (st_dest == DEST_W'(d));
            ld_req[d] = ld_valid && (ld_dest == DEST_W'(d));
            if (st_dest == DEST_W'(d)) st_ready = st_can[d];
            if (ld_dest == DEST_W'(d)) ld_ready = ld_can[d] && !same_dest;
        end
        for (int d = 0; d < NUM_DEST; d++) begin
            st_acc[d] = st_req[d] && st_ready;
            ld_acc[d] = ld_req[d] && ld_ready;
        end
    end

    generate
        for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
            sg_dest_buffer #(
                .ADDR_W (ADDR_W),
                .DATA_W (DATA_W),
                .BURST_W(BURST_W),
                .TMO_W  (TMO_W)
            ) u_buf (
                .clk       (clk),
                .rst_n     (rst_n),
                .idle_limit(idle_limit),
                .st_req    (st_req[d]),
                .ld_req    (ld_req[d]),
                .st_acc    (st_acc[d]),
                .ld_acc    (ld_acc[d]),
                .st_addr   (st_addr),
                .st_data   (st_data),
                .st_be     (st_be),
                .ld_addr   (ld_addr),
                .send      (grant[d]),
                .st_can    (st_can[d]),
                .ld_can    (ld_can[d]),
                .pending   (pend[d]),
                .kind      (kind_a[d]),
                .count     (cnt_a[d]),
                .payload   (pay_a[d]),
                .byte_en   (be_a[d])
            );
        end
    endgenerate

    sg_out_arb #(.NUM_DEST(NUM_DEST)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (pend),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .sel      (sel),
        .grant    (grant)
    );

    // Output mux of the selected buffer.
    always_comb begin
        out_dest    = sel;
        out_kind    = kind_a[sel];
        out_count   = cnt_a[sel];
        out_payload = pay_a[sel];
        out_byte_en = be_a[sel];
    end

    // R9: a shared destination in one cycle never lets the load in.
    a_r9_store_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && ld_valid && st_dest == ld_dest) |-> !ld_ready);
    // R10: a stalled burst keeps its contents and header.
    a_r10_stable_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_payload) && $stable(out_count)
                                       && $stable(out_byte_en) && $stable(out_kind)));
    // R5: a presented burst has between one slot and its type's capacity.
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count != '0 &&
                       out_count <= CNT_W'(out_kind ? ST_SLOTS : LD_SLOTS)));
    // R2: load bursts carry no byte-valid bits.
    a_r2_load_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_kind) |-> out_byte_en == '0);
endmodule

// File: tb/tb_sg_packer.sv
// Directed bench for sg_packer: one task per scenario.
module tb_sg_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   idle_limit = 8'd200;
    logic         st_valid = 1'b0, ld_valid = 1'b0, out_ready = 1'b0;
    logic         st_ready, ld_ready, out_valid, out_dest, out_kind;
    logic [0:0]   st_dest = '0, ld_dest = '0;
    logic [63:0]  st_addr = '0, st_data = '0, ld_addr = '0;
    logic [7:0]   st_be = '0;
    logic [3:0]   out_count;
    logic [31:0]  out_byte_en;
    logic [511:0] out_payload;
    int           n_chk = 0, n_bad = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    sg_packer dut (
        .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
        .st_valid(st_valid), .st_ready(st_ready), .st_dest(st_dest),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_dest(ld_dest),
        .ld_addr(ld_addr), .out_valid(out_valid), .out_ready(out_ready),
        .out_dest(out_dest), .out_kind(out_kind), .out_count(out_count),
        .out_byte_en(out_byte_en), .out_payload(out_payload)
    );

    task automatic check(input bit ok, input string req, input logic [511:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        st_valid = 1'b0; ld_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present a store from a negedge until accepted; returns at the negedge after.
    task automatic push_st(input logic d, input logic [63:0] a, dt, input logic [7:0] be);
        st_valid = 1'b1; st_dest = d; st_addr = a; st_data = dt; st_be = be;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic push_ld(input logic d, input logic [63:0] a);
        ld_valid = 1'b1; ld_dest = d; ld_addr = a;
        #1;
        while (!ld_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Wait for a burst, compare every field, then take it.
    task automatic collect(input string req, input logic d, input logic k, input logic [3:0] c,
                           input logic [511:0] pay, input logic [31:0] be);
        int w = 0;
        while (!out_valid && w < 50) begin @(negedge clk); w++; end
        check(out_valid, {req, " out_valid"}, 512'(out_valid), 512'(1));
        check(out_dest == d, {req, " R8 out_dest"}, 512'(out_dest), 512'(d));
        check(out_kind == k, {req, " out_kind"}, 512'(out_kind), 512'(k));
        check(out_count == c, {req, " R5 out_count"}, 512'(out_count), 512'(c));
        check(out_payload == pay, {req, " R6 payload"}, out_payload, pay);
        check(out_byte_en == be, {req, " byte_en"}, 512'(out_byte_en), 512'(be));
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(!out_valid, "R11 out_valid after reset", 512'(out_valid), 0);
        check(st_ready, "R11 st_ready after reset", 512'(st_ready), 512'(1));
        check(ld_ready, "R11 ld_ready after reset", 512'(ld_ready), 512'(1));
    endtask

    task automatic t_store_full();
        logic [511:0] pay = '0;
        logic [31:0]  be = '0;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            push_st(1'b0, 64'hA000 + 64'(i), 64'hD0D0_0000 + 64'(i * 17), 8'(8'h11 << i));
            pay[128*i +: 128] = {64'hD0D0_0000 + 64'(i * 17), 64'hA000 + 64'(i)};
            be[8*i +: 8] = 8'(8'h11 << i);
        end
        st_valid = 1'b1; st_dest = 1'b0; #1;
        check(!st_ready, "R3 store ready low while full", 512'(st_ready), 0);
        st_valid = 1'b0;
        collect("R1 store full", 1'b0, 1'b1, 4'd4, pay, be);
    endtask

    task automatic t_load_full();
        logic [511:0] pay = '0;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            push_ld(1'b1, 64'hBEEF_0000 + 64'(i * 8));
            pay[64*i +: 64] = 64'hBEEF_0000 + 64'(i * 8);
        end
        ld_valid = 1'b1; ld_dest = 1'b1; #1;
        check(!ld_ready, "R3 load ready low while full", 512'(ld_ready), 0);
        ld_valid = 1'b0;
        collect("R2 load full", 1'b1, 1'b0, 4'd8, pay, '0);
    endtask

    task automatic t_timeout();
        do_reset();
        idle_limit = 8'd5;
        push_ld(1'b0, 64'h1234);
        for (int i = 1; i <= 5; i++) begin
            @(posedge clk); @(negedge clk);
            check(out_valid == (i == 5), "R4 timeout cycle", 512'(out_valid), 512'(i == 5));
        end
        collect("R5 partial load", 1'b0, 1'b0, 4'd1, 512'(64'h1234), '0);
        idle_limit = 8'd200;
    endtask

    task automatic t_conflict();
        logic [511:0] pay = '0;
        do_reset();
        push_st(1'b1, 64'h10, 64'h20, 8'hFF);
        push_st(1'b1, 64'h30, 64'h40, 8'h0F);
        pay[127:0] = {64'h20, 64'h10};
        pay[255:128] = {64'h40, 64'h30};
        ld_valid = 1'b1; ld_dest = 1'b1; ld_addr = 64'h99; #1;
        check(!ld_ready, "R7 load held off", 512'(ld_ready), 0);
        @(negedge clk);
        check(out_valid, "R7 conflict flush", 512'(out_valid), 512'(1));
        collect("R7 flushed stores", 1'b1, 1'b1, 4'd2, pay, 32'h0000_0FFF);
        push_ld(1'b1, 64'h99);
        idle_limit = 8'd2;
        collect("R7 load after flush", 1'b1, 1'b0, 4'd1, 512'(64'h99), '0);
        idle_limit = 8'd200;
    endtask

    task automatic t_priority();
        do_reset();
        st_valid = 1'b1; st_dest = 1'b1; st_addr = 64'h5; st_data = 64'h6; st_be = 8'h01;
        ld_valid = 1'b1; ld_dest = 1'b1; ld_addr = 64'h7; #1;
        check(st_ready && !ld_ready, "R9 same dest store first", 512'({st_ready, ld_ready}), 512'(2'b10));
        ld_dest = 1'b0; #1;
        check(st_ready && ld_ready, "R9 distinct dest both ready", 512'({st_ready, ld_ready}), 512'(2'b11));
        @(posedge clk); @(negedge clk);
        st_valid = 1'b0; ld_valid = 1'b0;
        idle_limit = 8'd3;
        collect("R8 dest0 load", 1'b0, 1'b0, 4'd1, 512'(64'h7), '0);
        collect("R8 dest1 store", 1'b1, 1'b1, 4'd1, 512'({64'h6, 64'h5}), 32'h1);
        idle_limit = 8'd200;
    endtask

    task automatic t_hold();
        logic [511:0] lp = '0, sp = '0;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            push_ld(1'b1, 64'(i + 100));
            lp[64*i +: 64] = 64'(i + 100);
        end
        for (int i = 0; i < 4; i++) begin
            push_st(1'b0, 64'(i), 64'(i + 50), 8'h80);
            sp[128*i +: 128] = {64'(i + 50), 64'(i)};
        end
        @(negedge clk);
        check(out_dest == 1'b1, "R10 held dest under stall", 512'(out_dest), 512'(1));
        collect("R10 first burst", 1'b1, 1'b0, 4'd8, lp, '0);
        collect("R10 second burst", 1'b0, 1'b1, 4'd4, sp, 32'h8080_8080);
    endtask

    task automatic t_reset_discard();
        do_reset();
        idle_limit = 8'd3;
        push_st(1'b1, 64'h77, 64'h88, 8'hFF);
        do_reset();
        repeat (10) @(negedge clk);
        check(!out_valid, "R11 partial discarded", 512'(out_valid), 0);
        idle_limit = 8'd200;
    endtask

    initial begin
        t_reset_state();
        t_store_full();
        t_load_full();
        t_timeout();
        t_conflict();
        t_priority();
        t_hold();
        t_reset_discard();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule